// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small 8-bit Core

This block is the interrupt logic of a small 8-bit processor core. It serves five sources: one external pin, which it watches for a high-to-low transition, and four timer/event counters, whose overflow pulses it latches. Software sees the block as two 8-bit control words. They hold a global enable, one enable per source and one request flag per source. Software can read and write both words over a simple register port.

The core tells the block when its instruction-cycle sampling point is reached by pulsing `sample_en`. On that cycle the block looks at the latched flags. It picks the highest-priority source that is pending and enabled. If the global enable is on and the return stack has room, it raises a one-cycle call request together with a fixed vector address. Taking the interrupt clears both the serviced flag and the global enable. A return-from-interrupt strobe turns the global enable back on. A plain return strobe leaves it as it is.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control words read 0x00, `call_req` is 0 and `call_vec` is 0x00.
- R2: Word 0 (`reg_sel`=0) holds bit0 global enable, bit1 external enable, bit2 timer0 enable, bit3 timer1 enable, bit4 external flag, bit5 timer0 flag and bit6 timer1 flag; bit7 reads 0. Word 1 (`reg_sel`=1) holds bit0 timer2 enable, bit1 timer3 enable, bit4 timer2 flag and bit5 timer3 flag; bits 2, 3, 6 and 7 read 0. A write takes effect on the next clock edge.
- R3: A high-to-low transition on `ext_pin` sets the external flag. Holding the pin low, or driving it high, sets nothing.
- R4: A one-cycle pulse on `tmr_ovf[i]` sets the flag of timer i.
- R5: A call is issued only on a cycle with `sample_en` high, with the global enable set, and with some source whose enable and already-latched flag are both set. A flag that is latched in the same cycle as the sample waits for the next sample. `call_req` is high for exactly the one cycle after the sampling edge.
- R6: The vector addresses are: external 0x04, timer0 0x08, timer1 0x0C, timer2 0x10, timer3 0x14.
- R7: When several sources are eligible, the priority order is external, timer0, timer1, timer2, timer3.
- R8: Taking an interrupt clears the serviced flag and the global enable. Other flags and all per-source enables are unchanged.
- R9: `reti_strobe` sets the global enable. `ret_strobe` leaves it unchanged.
- R10: A hardware set of a flag in the same cycle as a software clear of that flag, or as that flag's acknowledge, leaves the flag set.
- R11: While `stack_full` is high no call is issued, and the pending request is kept for a later sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Instruction-cycle sampling point strobe |
| ext_pin | input | 1 | External interrupt pin (synchronous to clk) |
| tmr_ovf | input | 4 | Overflow pulses of timers 0..3 |
| stack_full | input | 1 | Return stack has no free entry |
| ret_strobe | input | 1 | Plain return executed |
| reti_strobe | input | 1 | Return-from-interrupt executed |
| reg_wr | input | 1 | Control word write strobe |
| reg_sel | input | 1 | Control word select (0 or 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected word |
| call_req | output | 1 | One-cycle interrupt call request |
| call_vec | output | 8 | Vector address of the call |

## Verification
A flag can receive a hardware set in the same cycle in which it is also cleared, either by a software write or by its own acknowledge. The bench provokes this in two ways. It writes zero to word 0 while timer0 overflows, and it pulses `sample_en` on timer0's pending flag while the next overflow arrives. It then reads word 0 back and expects the flag still set. A second collision happens when the external falling edge lands on the sampling cycle itself. For that case the bench expects no call, then a call at the next sample.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NTMR = 4;
    localparam int NSRC = NTMR + 1;
    localparam int RW   = 8;
    localparam int IW   = $clog2(NSRC);

    typedef struct packed {
        logic            mst;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flg;
        logic            call;
        logic [RW-1:0]   vec;
    } irq_state_t;

    function automatic logic [RW-1:0] vec_of(input logic [IW-1:0] idx, input int base, input int step);
        return RW'(base + step * int'(idx));
    endfunction
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~pin;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign gnt[i]         = req[i] & ~blocked[i];
            assign blocked[i + 1] = blocked[i] | req[i];
        end
    endgenerate

    assign any = blocked[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        if (!$isunknown(req)) begin
            assert_grant_onehot_R7: assert ($onehot0(gnt))
                else $error("grant not one-hot");
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_en,
    input  logic            ext_pin,
    input  logic [NTMR-1:0] tmr_ovf,
    input  logic            stack_full,
    input  logic            ret_strobe,
    input  logic            reti_strobe,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    output logic            call_req,
    output logic [RW-1:0]   call_vec
);
    localparam logic [RW-1:0] VEC_LO = RW'(VEC_BASE);
    localparam logic [RW-1:0] VEC_HI = RW'(VEC_BASE + VEC_STEP * (NSRC - 1));

    irq_state_t st_d, st_q;

    logic            fall_w;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] gnt;
    logic            any_w;
    logic [IW-1:0]   idx_w;
    logic            take;
    logic            unused_bits;

    irq_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .fall  (fall_w)
    );

    assign hw_set = {tmr_ovf, fall_w};
    assign pend   = st_q.en & st_q.flg & {NSRC{st_q.mst}};

    irq_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req (pend),
        .gnt (gnt),
        .any (any_w),
        .idx (idx_w)
    );

    assign take = sample_en & ~stack_full & any_w;

    always_comb begin
        st_d      = st_q;
        st_d.call = 1'b0;
        if (reg_wr) begin
            if (!reg_sel) begin
                st_d.mst      = reg_wdata[0];
                st_d.en[2:0]  = reg_wdata[3:1];
                st_d.flg[2:0] = reg_wdata[6:4];
            end else begin
                st_d.en[4:3]  = reg_wdata[1:0];
                st_d.flg[4:3] = reg_wdata[5:4];
            end
        end
        if (reti_strobe) st_d.mst = 1'b1;
        if (take) begin
            st_d.mst  = 1'b0;
            st_d.flg  = st_d.flg & ~gnt;
            st_d.call = 1'b1;
            st_d.vec  = vec_of(idx_w, VEC_BASE, VEC_STEP);
        end
        st_d.flg = st_d.flg | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata   = reg_sel ? {2'b00, st_q.flg[4:3], 2'b00, st_q.en[4:3]}
                                 : {1'b0, st_q.flg[2:0], st_q.en[2:0], st_q.mst};
    assign call_req    = st_q.call;
    assign call_vec    = st_q.vec;
    assign unused_bits = reg_wdata[7];

    assert_call_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(sample_en && !stack_full))
        else $error("call without sample or with full stack");

    assert_take_clears_mst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !st_q.mst)
        else $error("global enable survived a call");

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec >= VEC_LO && call_vec <= VEC_HI))
        else $error("vector out of range");

    assert_reti_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_strobe && !take) |=> st_q.mst)
        else $error("reti did not enable");

    assert_ret_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !reti_strobe && !take && !reg_wr) |=> $stable(st_q.mst))
        else $error("ret changed global enable");

    assert_fall_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w |=> st_q.flg[0])
        else $error("falling edge lost");

    assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((st_q.flg & $past(hw_set)) == $past(hw_set)))
        else $error("hardware set lost");
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       ext_pin = 1'b1;
    logic [3:0] tmr_ovf = '0;
    logic       stack_full = 1'b0;
    logic       ret_strobe = 1'b0;
    logic       reti_strobe = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       call_req;
    logic [7:0] call_vec;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 0;
    logic [7:0] v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .ext_pin(ext_pin),
        .tmr_ovf(tmr_ovf), .stack_full(stack_full), .ret_strobe(ret_strobe),
        .reti_strobe(reti_strobe), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .call_req(call_req),
        .call_vec(call_vec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic sample();
        sample_en = 1'b1;
        tick();
        sample_en = 1'b0;
    endtask

    task automatic clear_all();
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_reset();
        rd(1'b0, v); chk("R1 word0", v, 8'h00);
        rd(1'b1, v); chk("R1 word1", v, 8'h00);
        chk("R1 call_req", {7'b0, call_req}, 8'h00);
        chk("R1 call_vec", call_vec, 8'h00);
    endtask

    task automatic t_regs();
        wr(1'b0, 8'hFF); rd(1'b0, v); chk("R2 word0 bit7 reads 0", v, 8'h7F);
        wr(1'b1, 8'hFF); rd(1'b1, v); chk("R2 word1 mask", v, 8'h33);
        wr(1'b0, 8'h5A); rd(1'b0, v); chk("R2 word0 pattern", v, 8'h5A);
        clear_all();
        chk("R5 no call without sample", {7'b0, call_req}, 8'h00);
    endtask

    task automatic t_edge();
        ext_pin = 1'b0; tick();
        rd(1'b0, v); chk("R3 fall sets flag", v, 8'h10);
        wr(1'b0, 8'h00);
        repeat (3) tick();
        rd(1'b0, v); chk("R3 low level no set", v, 8'h00);
        ext_pin = 1'b1; tick(); tick();
        rd(1'b0, v); chk("R3 rise no set", v, 8'h00);
    endtask

    task automatic t_timers();
        for (int i = 0; i < 4; i++) begin
            tmr_ovf = 4'(1 << i); tick(); tmr_ovf = '0;
        end
        rd(1'b0, v); chk("R4 timer0/1 flags", v, 8'h60);
        rd(1'b1, v); chk("R4 timer2/3 flags", v, 8'h30);
        clear_all();
    endtask

    task automatic take_one(input int idx);
        clear_all();
        if (idx < 3) begin
            wr(1'b0, 8'(1 | (1 << (idx + 1)) | (1 << (idx + 4))));
        end else begin
            wr(1'b1, 8'((1 << (idx - 3)) | (1 << (idx + 1))));
            wr(1'b0, 8'h01);
        end
        sample();
        chk("R5 call raised", {7'b0, call_req}, 8'h01);
        chk("R6 vector", call_vec, 8'(4 * (idx + 1)));
        rd(1'b0, v); chk("R8 word0 after take", v, (idx < 3) ? 8'(1 << (idx + 1)) : 8'h00);
        rd(1'b1, v); chk("R8 word1 after take", v, (idx < 3) ? 8'h00 : 8'(1 << (idx - 3)));
        tick();
        chk("R5 call one cycle", {7'b0, call_req}, 8'h00);
    endtask

    task automatic t_priority();
        clear_all();
        wr(1'b1, 8'h33);
        wr(1'b0, 8'h7F);
        for (int k = 0; k < 5; k++) begin
            if (k > 0) begin
                reti_strobe = 1'b1; tick(); reti_strobe = 1'b0;
            end
            sample();
            chk("R7 priority order", call_vec, 8'(4 * (k + 1)));
            if (k == 0) begin
                rd(1'b0, v); chk("R8 others kept", v, 8'h6E);
            end
        end
        clear_all();
    endtask

    task automatic t_gating();
        wr(1'b0, 8'h11); sample();
        chk("R5 source disabled", {7'b0, call_req}, 8'h00);
        wr(1'b0, 8'h12); sample();
        chk("R5 global disabled", {7'b0, call_req}, 8'h00);
        wr(1'b0, 8'h03);
        ext_pin = 1'b0; sample_en = 1'b1; tick(); sample_en = 1'b0; ext_pin = 1'b1;
        chk("R5 late flag waits", {7'b0, call_req}, 8'h00);
        rd(1'b0, v); chk("R5 flag latched", v, 8'h13);
        sample();
        chk("R5 taken next sample", {7'b0, call_req}, 8'h01);
        clear_all();
    endtask

    task automatic t_stack();
        wr(1'b0, 8'h13);
        stack_full = 1'b1; sample();
        chk("R11 held off", {7'b0, call_req}, 8'h00);
        rd(1'b0, v); chk("R11 request kept", v, 8'h13);
        stack_full = 1'b0; sample();
        chk("R11 taken later", {7'b0, call_req}, 8'h01);
        chk("R11 vector", call_vec, 8'h04);
    endtask

    task automatic t_ret();
        ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
        rd(1'b0, v); chk("R9 ret keeps off", v, 8'h02);
        reti_strobe = 1'b1; tick(); reti_strobe = 1'b0;
        rd(1'b0, v); chk("R9 reti enables", v, 8'h03);
        ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
        rd(1'b0, v); chk("R9 ret keeps on", v, 8'h03);
        clear_all();
    endtask

    task automatic t_race();
        tmr_ovf = 4'b0001;
        wr(1'b0, 8'h00);
        tmr_ovf = '0;
        rd(1'b0, v); chk("R10 set beats sw clear", v, 8'h20);
        wr(1'b0, 8'h25);
        tmr_ovf = 4'b0001; sample_en = 1'b1; tick(); tmr_ovf = '0; sample_en = 1'b0;
        chk("R10 call taken", call_vec, 8'h08);
        rd(1'b0, v); chk("R10 set beats ack clear", v, 8'h24);
        clear_all();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regs();
        t_edge();
        t_timers();
        for (int i = 0; i < 5; i++) take_one(i);
        t_priority();
        t_gating();
        t_stack();
        t_ret();
        t_race();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule